// File: doc/BRIEF.md
# Level-Run Merging Pulse Builder

The block collects a waveform as a list of level runs. Each incoming pulse carries a duration and a level. The block stores only durations. The level of any run follows from the list's start level and the run's position, and consecutive runs always alternate. A pulse at the same level as the current last run therefore lengthens that run and does not open a zero-length edge.

The same input channel can also append a whole second run list. A header beat gives the second list's head level and its run count. The run beats that follow are then folded in with alternating levels. When the last run of the stored list has the same level as the head of the appended list, the two boundary runs become one. A concatenation that could not fit is refused as a whole before any of its runs is written.

A combinational readout port returns any stored run by index, with its duration and its derived level. A clear input empties the list.

Top module: `run_list_builder`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `runCount` is 0 and `overflow` is 0. `clear` overrides any operation. `opReady` is low while `clear` is high.
- R2: A pulse (`opCode`=0) accepted into an empty list sets `startLevel` to its level, stores its duration as run 0, and makes `runCount` 1. `startLevel` does not change while the list is non-empty.
- R3: The level of the last run is `startLevel` when `runCount` is odd and its inverse when `runCount` is even. A pulse whose level differs from that level is stored as a new run at index `runCount`, and the count rises by one.
- R4: A pulse at the same level as the last run adds its duration, modulo 2^32, to the last run. `runCount` stays the same.
- R5: When `runCount` equals CAP, a pulse that needs a new run writes nothing, leaves the count at CAP and sets `overflow`. `overflow` stays set until clear. A same-level pulse still merges into the last run when the list is full.
- R6: A header beat (`opCode`=1) carries the head level on `opLevel` and the appended run count on `opData`. If `runCount` plus that count is at most CAP, the following run beats (`opCode`=2) are added as runs whose levels alternate, starting at the head level. The first run merges into the last stored run when the levels match.
- R7: A concatenation onto an empty list gives the list the appended head level as `startLevel`.
- R8: A header whose count would take the list past CAP is refused. `catFail` is high for exactly the cycle after that header is accepted. The list is left unchanged, and the announced number of run beats that follow are dropped.
- R9: `rdValid` is 1 exactly when `rdIdx` < `runCount`. In that case `rdDur` is the stored duration and `rdLevel` is `startLevel` XOR bit 0 of `rdIdx`. Otherwise `rdDur` is 0. Both are combinational.
- R10: A run beat (`opCode`=2) with no concatenation pending, and `opCode`=3, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the list |
| opValid | input | 1 | Operation beat valid |
| opReady | output | 1 | Beat accepted when high with opValid |
| opCode | input | 2 | 0 pulse, 1 concatenation header, 2 concatenation run, 3 none |
| opLevel | input | 1 | Pulse level, or head level on a header |
| opData | input | DW (32) | Duration, or appended run count on a header |
| runCount | output | $clog2(CAP+1) | Number of stored runs |
| startLevel | output | 1 | Level of run 0 |
| overflow | output | 1 | Sticky: a pulse was lost to a full list |
| catFail | output | 1 | One-cycle refusal of a concatenation |
| rdIdx | input | $clog2(CAP) | Readout index |
| rdValid | output | 1 | rdIdx is below runCount |
| rdLevel | output | 1 | Level of the indexed run |
| rdDur | output | DW (32) | Duration of the indexed run |

## Verification
The pulse path is driven first with a same-level repeat and then with strictly alternating levels. This separates merging from appending and confirms the parity rule for the tail level. Filling the list to capacity and sending one pulse of each level separates the overflow path from a merge into a full list. Concatenations are tried onto an empty list, with a matching and a mismatching boundary, at exactly full capacity, and one run past it. These cases distinguish adopting the head level, merging the boundary runs, and refusing the whole list with its beats dropped. Duration sums that wrap past 2^32 and stray run beats complete the patterns.

// File: rtl/run_list_pkg.sv
package run_list_pkg;

  typedef enum logic [1:0] {
    OP_PULSE    = 2'd0,
    OP_CAT_HEAD = 2'd1,
    OP_CAT_RUN  = 2'd2,
    OP_NONE     = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrNew;  // store data as a fresh run
    logic accum;  // add data to an existing run
  } run_strobe_t;

endpackage

// File: rtl/run_list_ctrl.sv
module run_list_ctrl
  import run_list_pkg::*;
#(
  parameter int CAP = 64,
  parameter int DW  = 32,
  localparam int CW = $clog2(CAP + 1),
  localparam int IW = (CAP > 1) ? $clog2(CAP) : 1,
  localparam int LW = DW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          opValid,
  input  logic [1:0]    opCode,
  input  logic          opLevel,
  input  logic [DW-1:0] opData,
  output logic          opReady,
  output run_strobe_t   strobe,
  output logic [IW-1:0] wrIdx,
  output logic [CW-1:0] runCount,
  output logic          startLevel,
  output logic          overflow,
  output logic          catFail
);

  logic [DW-1:0] catLeft;
  logic          catDropping;
  logic          catLevel;

  op_e  opKind;
  logic fire;
  logic doAdd;
  logic addLevel;
  logic tailLevel;
  logic listFull;
  logic listEmpty;
  logic newRun;
  logic catPending;
  logic catReject;

  assign opKind     = op_e'(opCode);
  assign opReady    = !clear;
  assign fire       = opValid && !clear;
  assign listFull   = (runCount == CW'(CAP));
  assign listEmpty  = (runCount == '0);
  assign tailLevel  = startLevel ^ ~runCount[0];
  assign catPending = (catLeft != '0);
  assign catReject  = ({1'b0, opData} + LW'(runCount)) > LW'(CAP);

  always_comb begin
    doAdd    = 1'b0;
    addLevel = opLevel;
    unique case (opKind)
      OP_PULSE:   doAdd = fire;
      OP_CAT_RUN: begin
        doAdd    = fire && catPending && !catDropping;
        addLevel = catLevel;
      end
      default:    doAdd = 1'b0;
    endcase
  end

  assign newRun = listEmpty || (addLevel != tailLevel);

  always_comb begin
    strobe = '0;
    wrIdx  = '0;
    if (doAdd) begin
      if (listEmpty) begin
        strobe.wrNew = 1'b1;
        wrIdx        = '0;
      end else if (newRun) begin
        strobe.wrNew = !listFull;
        wrIdx        = IW'(runCount);
      end else begin
        strobe.accum = 1'b1;
        wrIdx        = IW'(runCount - CW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount    <= '0;
      startLevel  <= 1'b0;
      overflow    <= 1'b0;
      catFail     <= 1'b0;
      catLeft     <= '0;
      catDropping <= 1'b0;
      catLevel    <= 1'b0;
    end else if (clear) begin
      runCount    <= '0;
      startLevel  <= 1'b0;
      overflow    <= 1'b0;
      catFail     <= 1'b0;
      catLeft     <= '0;
      catDropping <= 1'b0;
      catLevel    <= 1'b0;
    end else begin
      catFail <= 1'b0;
      if (doAdd) begin
        if (listEmpty) begin
          startLevel <= addLevel;
          runCount   <= CW'(1);
        end else if (newRun) begin
          if (listFull) overflow <= 1'b1;
          else          runCount <= runCount + CW'(1);
        end
      end
      if (fire && opKind == OP_CAT_RUN && catPending) begin
        catLeft  <= catLeft - DW'(1);
        catLevel <= ~catLevel;
      end
      if (fire && opKind == OP_CAT_HEAD) begin
        catFail     <= catReject;
        catDropping <= catReject;
        catLeft     <= opData;
        catLevel    <= opLevel;
      end
    end
  end

endmodule

// File: rtl/run_list_store.sv
module run_list_store
  import run_list_pkg::*;
#(
  parameter int CAP = 64,
  parameter int DW  = 32,
  localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
  input  logic          clk,
  input  run_strobe_t   strobe,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] rdIdx,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] runMem [CAP];

  for (genvar e = 0; e < CAP; e++) begin : g_entry
    logic hit;
    assign hit = (wrIdx == IW'(e));
    always_ff @(posedge clk) begin
      if (hit && strobe.wrNew)      runMem[e] <= wrData;
      else if (hit && strobe.accum) runMem[e] <= runMem[e] + wrData;
    end
  end

  assign rdData = runMem[rdIdx];

endmodule

// File: rtl/run_list_builder.sv
module run_list_builder
  import run_list_pkg::*;
#(
  parameter int CAP = 64,
  parameter int DW  = 32,
  localparam int CW = $clog2(CAP + 1),
  localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          opValid,
  output logic          opReady,
  input  logic [1:0]    opCode,
  input  logic          opLevel,
  input  logic [DW-1:0] opData,
  output logic [CW-1:0] runCount,
  output logic          startLevel,
  output logic          overflow,
  output logic          catFail,
  input  logic [IW-1:0] rdIdx,
  output logic          rdValid,
  output logic          rdLevel,
  output logic [DW-1:0] rdDur
);

  run_strobe_t   strobe;
  logic [IW-1:0] wrIdx;
  logic [DW-1:0] rdData;

  run_list_ctrl #(.CAP(CAP), .DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear),
    .opValid(opValid), .opCode(opCode), .opLevel(opLevel), .opData(opData),
    .opReady(opReady), .strobe(strobe), .wrIdx(wrIdx),
    .runCount(runCount), .startLevel(startLevel),
    .overflow(overflow), .catFail(catFail)
  );

  run_list_store #(.CAP(CAP), .DW(DW)) uStore (
    .clk(clk), .strobe(strobe), .wrIdx(wrIdx), .wrData(opData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  assign rdValid = (CW'(rdIdx) < runCount);
  assign rdLevel = startLevel ^ rdIdx[0];
  assign rdDur   = rdValid ? rdData : '0;

endmodule

// File: rtl/run_list_chk.sv
module run_list_chk #(
  parameter int CAP = 64,
  parameter int CW  = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          clear,
  input logic [CW-1:0] runCount,
  input logic          startLevel,
  input logic          overflow,
  input logic          catFail
);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (runCount == '0 && !overflow)); // R1

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (runCount != '0 && !clear) |=> (startLevel == $past(startLevel))); // R2

  AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (runCount == $past(runCount) || runCount == $past(runCount) + CW'(1))); // R3

  AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= CW'(CAP)); // R5

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clear) |=> overflow); // R5

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    catFail |-> (runCount == $past(runCount))); // R8

endmodule

bind run_list_builder run_list_chk #(.CAP(CAP), .CW(CW)) uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .runCount(runCount),
  .startLevel(startLevel), .overflow(overflow), .catFail(catFail)
);

// File: tb/sim_run_list_builder.sv
`timescale 1ns/1ps
module sim_run_list_builder;
  localparam int CAP = 8;
  localparam int DW  = 32;
  localparam int CW  = $clog2(CAP + 1);
  localparam int IW  = $clog2(CAP);

  logic clk = 0, rstN = 0, clear = 0, opValid = 0, opLevel = 0;
  logic [1:0] opCode = 0;
  logic [DW-1:0] opData = 0;
  logic [IW-1:0] rdIdx = 0;
  logic opReady, startLevel, overflow, catFail, rdValid, rdLevel;
  logic [CW-1:0] runCount;
  logic [DW-1:0] rdDur;

  always #2 clk = ~clk;

  run_list_builder #(.CAP(CAP), .DW(DW)) u0 (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  typedef struct { int cnt; bit st; bit ovf; bit fail; string tag; } exp_t;
  exp_t q[$];

  // bench model built from the requirements
  int mCount = 0, mRem = 0, mDrop = 0;
  bit mStart = 0, mOvf = 0, mFail = 0, mCatLvl = 0;
  logic [DW-1:0] mRuns [CAP];

  function automatic void mAdd(bit lvl, logic [DW-1:0] d);
    bit tail;
    if (mCount == 0) begin mStart = lvl; mRuns[0] = d; mCount = 1; return; end
    tail = (mCount % 2 == 1) ? mStart : !mStart;
    if (lvl != tail) begin
      if (mCount == CAP) mOvf = 1;
      else begin mRuns[mCount] = d; mCount++; end
    end else mRuns[mCount-1] = mRuns[mCount-1] + d;
  endfunction

  function automatic void mStep(logic [1:0] code, bit lvl, logic [DW-1:0] d);
    mFail = 0;
    case (code)
      2'd0: mAdd(lvl, d);
      2'd1: begin
        if (d > CAP - mCount) begin mFail = 1; mDrop = d; mRem = 0; end
        else begin mRem = d; mDrop = 0; mCatLvl = lvl; end
      end
      2'd2: begin
        if (mRem > 0) begin mAdd(mCatLvl, d); mCatLvl = !mCatLvl; mRem--; end
        else if (mDrop > 0) mDrop--;
      end
      default: ;
    endcase
  endfunction

  // driver: one beat, expected state pushed to the scoreboard
  task automatic op(logic [1:0] code, bit lvl, logic [DW-1:0] d, string tag);
    exp_t e;
    @(negedge clk);
    opValid = 1; opCode = code; opLevel = lvl; opData = d;
    @(posedge clk); #1;
    opValid = 0;
    mStep(code, lvl, d);
    e.cnt = mCount; e.st = mStart; e.ovf = mOvf; e.fail = mFail; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic doClear(string tag);
    exp_t e;
    @(negedge clk);
    clear = 1; opValid = 1; opCode = 2'd0; opLevel = 1; opData = 99;
    #1;
    checks++;
    if (opReady !== 1'b0) begin
      errors++; $display("FAIL %s opReady got %b exp 0", tag, opReady);
    end
    @(posedge clk); #1;
    clear = 0; opValid = 0;
    mCount = 0; mStart = 0; mOvf = 0; mFail = 0; mRem = 0; mDrop = 0;
    e.cnt = 0; e.st = 0; e.ovf = 0; e.fail = 0; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (runCount !== CW'(e.cnt) || startLevel !== e.st || overflow !== e.ovf || catFail !== e.fail) begin
        errors++;
        $display("FAIL %s got cnt=%0d st=%b ovf=%b fail=%b exp cnt=%0d st=%b ovf=%b fail=%b",
                 e.tag, runCount, startLevel, overflow, catFail, e.cnt, e.st, e.ovf, e.fail);
      end
    end
  end

  // R9 readout of every index against the model
  task automatic readAll(string tag);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    for (int i = 0; i < CAP; i++) begin
      bit v;
      logic [DW-1:0] dd;
      rdIdx = IW'(i); #1;
      v = (i < mCount);
      dd = v ? mRuns[i] : '0;
      checks++;
      if (rdValid !== v || rdDur !== dd || (v && rdLevel !== (mStart ^ i[0]))) begin
        errors++;
        $display("FAIL R9 %s idx %0d got v=%b d=%0d l=%b exp v=%b d=%0d l=%b",
                 tag, i, rdValid, rdDur, rdLevel, v, dd, mStart ^ i[0]);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    checks++;
    if (runCount !== 0 || overflow !== 0 || opReady !== 1 || catFail !== 0) begin
      errors++; $display("FAIL R1 reset got cnt=%0d ovf=%b rdy=%b exp 0 0 1", runCount, overflow, opReady);
    end
    readAll("R1 empty after reset");

    op(0, 1, 10, "R2 first pulse");
    op(0, 1, 5,  "R4 same level merge");
    op(0, 0, 7,  "R3 new run");
    op(0, 1, 3,  "R3 new run odd");
    op(0, 1, 4,  "R4 merge tail");
    readAll("R3 R4 content");

    op(0, 0, 1, "R3 fill"); op(0, 1, 2, "R3 fill"); op(0, 0, 3, "R3 fill");
    op(0, 1, 4, "R3 fill"); op(0, 0, 5, "R3 fill to cap");
    op(0, 1, 9, "R5 overflow when full");
    op(0, 0, 2, "R5 merge while full");
    op(1, 0, 1, "R8 refuse when full");
    op(2, 0, 6, "R8 dropped beat");
    readAll("R5 full content");

    doClear("R1 clear");
    readAll("R1 empty after clear");

    op(1, 0, 3, "R7 header on empty");
    op(2, 0, 4, "R7 adopt head level");
    op(2, 0, 5, "R6 cat run"); op(2, 0, 6, "R6 cat run");
    op(1, 0, 2, "R6 header matching tail");
    op(2, 0, 9, "R6 boundary merge"); op(2, 0, 1, "R6 cat run");
    op(1, 0, 2, "R6 header mismatching tail");
    op(2, 1, 2, "R6 no merge"); op(2, 1, 3, "R6 cat run");
    readAll("R6 R7 content");

    op(2, 0, 8, "R10 stray run beat");
    op(3, 1, 8, "R10 no-op code");
    op(0, 1, 32'hFFFF_FFFF, "R4 wrapping merge");
    op(1, 1, 3, "R8 refuse one past cap");
    op(2, 0, 1, "R8 drop"); op(2, 0, 1, "R8 drop"); op(2, 0, 1, "R8 drop");
    op(0, 0, 7, "R3 after refuse");
    op(1, 1, 1, "R6 header exactly to cap");
    op(2, 1, 11, "R6 fills cap");
    readAll("R4 R8 R10 content");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired got running exp done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule